// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block sits on the controller side of a cache. It turns maintenance requests from a processor into a series of per-line commands on a simple tag/data command port. A range operation takes two register writes. The first write records a start address. The second write gives an end address of the same kind and starts a walk over every cache line whose base lies between the two addresses, with both ends included. While the walk runs, the engine raises a stall signal to the requester. Commands for one line by address, and one command that invalidates the whole cache, go through the same port.

The engine sends one command at a time and holds it until the command port acknowledges it. After each acknowledge it moves on to the next line, 32 bytes higher. The engine refuses an end write that breaks the arming rules: no lines are processed and an error flag is raised instead. The start and end of a range must lie in the same page, because only the start address is ever translated.

Top module: `crm_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `cmd_valid` and `err` are 0.
- R2: Request codes on `req_op` are: 0 clean-range start, 1 clean-range end, 2 invalidate-range start, 3 invalidate-range end, 4 clean line, 5 invalidate line, 6 clean-and-invalidate line, 7 invalidate all. A start write followed by the matching end write issues one command for each line base from start to end, both included, in ascending order 32 bytes apart. The command kind is 0 for clean and 1 for invalidate.
- R3: Address bits [4:0] of a request are ignored, and every `cmd_addr` is a line base with bits [4:0] equal to 0.
- R4: A command stays valid with the same address and kind until the cycle in which `cmd_ack` is sampled high. The next line's command appears in the following cycle.
- R5: `busy` is high from the cycle after a command-producing request is accepted, up to and including the cycle of the final acknowledge. `busy` is low in the cycle after that. A request presented while `busy` is high is ignored.
- R6: The single-line requests (codes 4, 5 and 6) issue exactly one command at the line base, with kind 0, 1 or 2 respectively.
- R7: Invalidate-all (code 7) issues exactly one command with kind 3 and address 0, whatever the operand.
- R8: An end write with no armed start of the same kind processes no lines and sets `err`.
- R9: An end write whose line is below the armed start line, or whose page (address bits above bit 11) differs from the start's page, processes no lines and sets `err`.
- R10: Any accepted request other than the matching end write discards an armed start. A later end write is then rejected as in R8.
- R11: `err` changes only when a request is accepted. It is then set to 1 if that request was a rejected end write, and cleared to 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Maintenance request present |
| req_op | input | 3 | Request code (see R2) |
| req_addr | input | AW | Request address operand |
| busy | output | 1 | Stall to the requester while a walk runs |
| err | output | 1 | Last accepted end write was rejected |
| cmd_valid | output | 1 | Per-line command valid |
| cmd_kind | output | 2 | 0 clean, 1 invalidate, 2 clean+invalidate, 3 invalidate all |
| cmd_addr | output | AW | Line base of the command |
| cmd_ack | input | 1 | Command port accepts the current command |

## Verification
The case that needs care is a new request arriving in the same cycle as the final acknowledge of a walk. At that clock edge the step logic finishes the walk while the request path is still blocked by `busy`. The bench provokes this by raising an invalidate-all request in the very cycle that the last `cmd_ack` is driven, and another at the first command of a walk. It judges the result by requiring that the walk's command count is exact and that no further command or busy cycle follows.

// File: rtl/crm_pkg.sv
package crm_pkg;

  typedef enum logic [2:0] {
    OP_CLN_START = 3'd0,
    OP_CLN_END   = 3'd1,
    OP_INV_START = 3'd2,
    OP_INV_END   = 3'd3,
    OP_LINE_CLN  = 3'd4,
    OP_LINE_INV  = 3'd5,
    OP_LINE_CI   = 3'd6,
    OP_INV_ALL   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    K_CLEAN = 2'd0,
    K_INV   = 2'd1,
    K_CI    = 2'd2,
    K_ALL   = 2'd3
  } kind_e;

endpackage

// File: rtl/crm_decode.sv
module crm_decode
  import crm_pkg::*;
#(
  parameter int LW = 27,
  parameter int PL = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  op_e           op,
  input  logic [LW-1:0] line,
  output logic          launch,
  output kind_e         l_kind,
  output logic [LW-1:0] l_first,
  output logic [LW-1:0] l_last,
  output logic          reject
);

  logic          armed_q, armed_d;
  kind_e         akind_q, akind_d;
  logic [LW-1:0] aline_q;
  logic          is_start;
  logic          range_ok;
  kind_e         want_kind;

  always_comb begin
    is_start  = (op == OP_CLN_START) || (op == OP_INV_START);
    want_kind = ((op == OP_CLN_START) || (op == OP_CLN_END)) ? K_CLEAN : K_INV;
    range_ok  = armed_q && (akind_q == want_kind) && (line >= aline_q) &&
                (line[LW-1:PL] == aline_q[LW-1:PL]);
    armed_d   = is_start;
    akind_d   = want_kind;
    launch    = 1'b0;
    reject    = 1'b0;
    l_kind    = K_CLEAN;
    l_first   = line;
    l_last    = line;
    unique case (op)
      OP_CLN_END, OP_INV_END: begin
        launch  = acc && range_ok;
        reject  = acc && !range_ok;
        l_kind  = want_kind;
        l_first = aline_q;
      end
      OP_LINE_CLN: begin launch = acc; l_kind = K_CLEAN; end
      OP_LINE_INV: begin launch = acc; l_kind = K_INV;   end
      OP_LINE_CI:  begin launch = acc; l_kind = K_CI;    end
      OP_INV_ALL: begin
        launch  = acc;
        l_kind  = K_ALL;
        l_first = '0;
        l_last  = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      akind_q <= K_CLEAN;
    end else if (acc) begin
      armed_q <= armed_d;
      akind_q <= akind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aline_q <= '0;
    else if (acc && is_start) aline_q <= line;
  end

endmodule

// File: rtl/crm_walker.sv
module crm_walker
  import crm_pkg::*;
#(
  parameter int LW = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  kind_e         l_kind,
  input  logic [LW-1:0] l_first,
  input  logic [LW-1:0] l_last,
  input  logic          ack,
  output logic          active,
  output kind_e         kind,
  output logic [LW-1:0] cur
);

  logic          act_q, act_d;
  kind_e         kind_q;
  logic [LW-1:0] cur_q, cur_d, last_q;
  logic          step, done, load_en;

  always_comb begin
    step    = act_q && ack;
    done    = step && (cur_q == last_q);
    load_en = launch || step;
    act_d   = launch ? 1'b1 : (done ? 1'b0 : act_q);
    cur_d   = launch ? l_first : cur_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cur_q <= '0;
    end else if (load_en) begin
      act_q <= act_d;
      cur_q <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_CLEAN;
      last_q <= '0;
    end else if (launch) begin
      kind_q <= l_kind;
      last_q <= l_last;
    end
  end

  assign active = act_q;
  assign kind   = kind_q;
  assign cur    = cur_q;

endmodule

// File: rtl/crm_engine.sv
module crm_engine
  import crm_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BITS  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          err,
  output logic          cmd_valid,
  output logic [1:0]    cmd_kind,
  output logic [AW-1:0] cmd_addr,
  input  logic          cmd_ack
);

  localparam int OFS = $clog2(LINE_BYTES);
  localparam int LW  = AW - OFS;
  localparam int PL  = PAGE_BITS - OFS;

  logic          acc, launch, reject, active;
  kind_e         l_kind, w_kind;
  logic [LW-1:0] l_first, l_last, cur;
  logic          err_q;

  assign acc = req_valid && !active;

  crm_decode #(.LW(LW), .PL(PL)) dec_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .op(op_e'(req_op)),
    .line(req_addr[AW-1:OFS]), .launch(launch), .l_kind(l_kind),
    .l_first(l_first), .l_last(l_last), .reject(reject)
  );

  crm_walker #(.LW(LW)) walk_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .l_kind(l_kind),
    .l_first(l_first), .l_last(l_last), .ack(cmd_ack),
    .active(active), .kind(w_kind), .cur(cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (acc) err_q <= reject;
  end

  assign busy      = active;
  assign err       = err_q;
  assign cmd_valid = active;
  assign cmd_kind  = w_kind;
  assign cmd_addr  = {cur, {OFS{1'b0}}};

endmodule

// File: rtl/crm_engine_chk.sv
module crm_engine_chk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          err,
  input logic          cmd_valid,
  input logic [1:0]    cmd_kind,
  input logic [AW-1:0] cmd_addr,
  input logic          cmd_ack
);

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_kind));

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ack |=> !cmd_valid ||
      (cmd_addr == $past(cmd_addr) + AW'(LINE_BYTES)));

  // R7
  inv_all_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == 2'd3) |-> cmd_addr == '0);

  // R5
  no_spont_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !req_valid |=> !busy);

  // R8
  err_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && !cmd_valid);

endmodule

bind crm_engine crm_engine_chk #(.AW(AW), .LINE_BYTES(LINE_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .err(err),
  .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
  .cmd_ack(cmd_ack)
);

// File: tb/crm_engine_tb_top.sv
`timescale 1ns/1ps
module crm_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [31:0] req_addr;
  logic        busy, err, cmd_valid, cmd_ack;
  logic [1:0]  cmd_kind;
  logic [31:0] cmd_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crm_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .busy(busy), .err(err), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_ack(cmd_ack)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lbase(input logic [31:0] a);
    return a & 32'hFFFF_FFE0;
  endfunction

  task automatic run(input logic [2:0] op, input logic [31:0] a, input int exp_n,
                     input logic [31:0] first, input logic [1:0] kind,
                     input bit exp_err, input bit poke, input string req);
    int n = 0;
    bit ack;
    req_valid = 1'b1; req_op = op; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy && !done) begin
      if (cmd_valid) begin
        chk(n < exp_n, req, "extra command", n, exp_n);
        chk(cmd_addr == 32'(first + 32'(n) * 32), req, "cmd_addr",
            cmd_addr, 32'(first + 32'(n) * 32));
        chk(cmd_kind == kind, req, "cmd_kind", cmd_kind, kind);
        ack = ($urandom % 3) != 0;
        cmd_ack = ack;
        if (poke && n == 0) begin req_valid = 1'b1; req_op = 3'd7; end
        if (ack) begin
          n++;
          // R5: request in the same cycle as the final acknowledge
          if (poke && n == exp_n) begin req_valid = 1'b1; req_op = 3'd7; end
        end
      end
      @(negedge clk);
      cmd_ack = 1'b0;
      req_valid = 1'b0;
    end
    chk(n == exp_n, req, "command count", n, exp_n);
    chk(err == exp_err, "R11", "err", err, exp_err);
    if (poke) begin
      repeat (2) begin
        @(negedge clk);
        chk(!busy && !cmd_valid, "R5", "ignored request started work", busy, 0);
      end
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; cmd_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !cmd_valid && !err, "R1", "reset outputs", {busy, cmd_valid, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cmd_valid && !err, "R1", "after reset", {busy, cmd_valid, err}, 0);

    // R6 / R3: single-line ops with unaligned operand
    run(3'd4, 32'h1000_0047, 1, 32'h1000_0040, 2'd0, 0, 0, "R6");
    run(3'd5, 32'h2000_011F, 1, 32'h2000_0100, 2'd1, 0, 0, "R3");
    run(3'd6, 32'h2000_0200, 1, 32'h2000_0200, 2'd2, 0, 0, "R6");
    // R7
    run(3'd7, 32'h0000_DEAD, 1, 32'h0, 2'd3, 0, 0, "R7");
    // R2: one-line range, full page range
    run(3'd0, 32'h4000_0060, 0, 0, 0, 0, 0, "R2");
    run(3'd1, 32'h4000_007F, 1, 32'h4000_0060, 2'd0, 0, 0, "R2");
    run(3'd2, 32'h0002_0000, 0, 0, 0, 0, 0, "R2");
    run(3'd3, 32'h0002_0FE0, 128, 32'h0002_0000, 2'd1, 0, 0, "R2");
    // R8: end without start, then cleared by a start (R11)
    run(3'd1, 32'h5000_0100, 0, 0, 0, 1, 0, "R8");
    run(3'd0, 32'h5000_0100, 0, 0, 0, 0, 0, "R11");
    // R8: kind mismatch
    run(3'd3, 32'h5000_0140, 0, 0, 0, 1, 0, "R8");
    // R9: end below start
    run(3'd2, 32'h6000_0200, 0, 0, 0, 0, 0, "R9");
    run(3'd3, 32'h6000_01E0, 0, 0, 0, 1, 0, "R9");
    // R9: crosses page
    run(3'd0, 32'h3000_0FE0, 0, 0, 0, 0, 0, "R9");
    run(3'd1, 32'h3000_1000, 0, 0, 0, 1, 0, "R9");
    // R10: intervening access discards start
    run(3'd2, 32'h7000_0000, 0, 0, 0, 0, 0, "R10");
    run(3'd4, 32'h7100_0000, 1, 32'h7100_0000, 2'd0, 0, 0, "R10");
    run(3'd3, 32'h7000_0040, 0, 0, 0, 1, 0, "R10");
    // R5: requests during a walk and on its final acknowledge are dropped
    run(3'd0, 32'h8000_0400, 0, 0, 0, 0, 0, "R5");
    run(3'd1, 32'h8000_04A0, 6, 32'h8000_0400, 2'd0, 0, 1, "R5");
    run(3'd5, 32'h8000_0800, 1, 32'h8000_0800, 2'd1, 0, 1, "R5");

    // R2 / R4: random ranges with random acknowledge gaps
    for (int i = 0; i < 40; i++) begin
      logic [31:0] page, s, e;
      int so, len;
      bit inv;
      page = $urandom & 32'hFFFF_F000;
      so   = $urandom % 120;
      len  = $urandom % 8;
      inv  = $urandom % 2;
      s = page + 32'(so) * 32 + ($urandom % 32);
      e = page + 32'(so + len) * 32 + ($urandom % 32);
      run(inv ? 3'd2 : 3'd0, s, 0, 0, 0, 0, 0, "R2");
      run(inv ? 3'd3 : 3'd1, e, len + 1, lbase(s), inv ? 2'd1 : 2'd0, 0,
          (i % 5) == 0, "R4");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule